// File: doc/BRIEF.md
# Banked GPIO Controller with Per-Group Enables

This block controls sixty-four general-purpose lines, organised as eight groups of eight. Line n is in group n/8 at bit n%8. Each group has one data byte in a run-time I/O window of eight bytes. The window starts at the address on the 16-bit `io_base` input. A host writes a data byte to set the drive values of its group. A host reads a data byte to see the current line levels. To change one line, the host reads the byte, modifies the bit and writes the byte back.

Two banks of configuration registers decide whether each line is driven. They are reached through a separate byte-wide configuration port.
- The direction bank sits at configuration addresses 0xC8 to 0xCF, one byte per group.
- The function-select bank sits at 0xC0 to 0xC4. Only groups 0 to 4 have a function-select byte. Groups 5 to 7 always act as GPIO, so for them the direction bit alone decides.

A line drives its pad only when its function-select bit (or the fixed function) and its direction bit are both 1.

Both host ports use single-cycle strobes with no back-pressure. The block accepts a strobe in every cycle. Read data comes back in the cycle after the strobe. No pad electrical features and no interrupts are provided.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: A run-time write to address `io_base`+g, with g from 0 to 7, stores the write byte as the drive values of group g. The stored values appear on `pad_out` at the next clock edge.
- R2: A run-time read that hits the window returns the group's byte on `io_rdata`, with `io_rvalid` high, in the cycle after `io_rd`. When `io_rvalid` is low, `io_rdata` is 0x00.
- R3: Run-time accesses outside `io_base` to `io_base`+7 are ignored. Address arithmetic does not wrap past 0xFFFF. A missed write changes no drive value, and a missed read leaves `io_rvalid` low and `io_rdata` at 0x00.
- R4: The configuration register at 0xC8+g holds the direction byte of group g. A 1 bit selects output and a 0 bit selects input. The register reads back as written.
- R5: The configuration register at 0xC0+g, for g from 0 to 4, holds the function-select byte of group g. A line in these groups drives only when its function-select bit and its direction bit are both 1.
- R6: Groups 5 to 7 have a fixed GPIO function. For these groups `pad_oe` equals the direction byte.
- R7: After reset, every direction bit, function-select bit and drive value is 0, so `pad_oe` and `pad_out` are all zero.
- R8: For a line that is not driven, a data read returns the pad level after two synchroniser flip-flops. A level held for two clocks before the read strobe is returned.
- R9: For a driven line, a data read returns the stored drive value, whatever the pad level is.
- R10: Configuration reads of 0xC5 to 0xC7, and of any other unmapped address, return 0x00 one cycle after `cfg_rd`. Writes to those addresses change nothing.
- R11: Line n uses bit n%8 of group n/8 in the data byte, in the direction byte and in the function-select byte. This makes single-line read-modify-write updates possible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_base | input | 16 | First address of the run-time data window |
| io_addr | input | 16 | Run-time access address |
| io_wr | input | 1 | Run-time write strobe |
| io_rd | input | 1 | Run-time read strobe |
| io_wdata | input | 8 | Run-time write byte |
| io_rdata | output | 8 | Run-time read byte, 0x00 when not valid |
| io_rvalid | output | 1 | High for one cycle when the window returns a read byte |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration read byte, one cycle after `cfg_rd` |
| pad_in | input | 64 | Asynchronous pad levels |
| pad_out | output | 64 | Pad drive values |
| pad_oe | output | 64 | Pad output enables |

## Verification
The assertions assume the following about the inputs:
- The strobes are known values from the first clock edge after reset.
- A read strobe and a write strobe on the same port are never asserted in the same cycle.
- `io_base` holds steady from one cycle before an access until its result is sampled.

The stimulus keeps to these assumptions as follows:
- Every strobe is raised for exactly one cycle from a task, and `io_base` is changed only between accesses.
- Inputs are driven on the falling edge, so each access falls in one known cycle.
- `pad_in` is changed only while the port is idle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // kind of configuration access decoded from an address
  typedef enum logic [1:0] {
    CFG_NONE = 2'd0,
    CFG_FUNC = 2'd1,
    CFG_DIR  = 2'd2
  } cfg_kind_e;

  // mix drive values and sampled levels: driven bits report the latch
  function automatic logic [7:0] mix_byte(input logic [7:0] drive,
                                          input logic [7:0] level,
                                          input logic [7:0] oe);
    return (drive & oe) | (level & ~oe);
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

  AST_SYNC_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, 2) |-> sync_out == $past(async_in, 2)) else $error("sync depth"); // R8
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_GROUPS  = 8,
  parameter int GROUP_W     = 8,
  parameter int FUNC_GROUPS = 5,
  parameter int FUNC_BASE   = 'hC0,
  parameter int DIR_BASE    = 'hC8,
  parameter int CFG_AW      = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic                          cfg_wr,
  input  logic                          cfg_rd,
  input  logic [GROUP_W-1:0]            cfg_wdata,
  output logic [GROUP_W-1:0]            cfg_rdata,
  output logic [NUM_GROUPS*GROUP_W-1:0] dir_flat,
  output logic [NUM_GROUPS*GROUP_W-1:0] func_flat
);
  localparam int LINES = NUM_GROUPS * GROUP_W;

  logic [GROUP_W-1:0] dir_q    [NUM_GROUPS];
  logic [GROUP_W-1:0] func_rb  [NUM_GROUPS];
  logic [GROUP_W-1:0] func_en  [NUM_GROUPS];
  logic [GROUP_W-1:0] rd_next;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam logic [CFG_AW-1:0] DIR_ADDR  = CFG_AW'(DIR_BASE + g);
    localparam logic [CFG_AW-1:0] FUNC_ADDR = CFG_AW'(FUNC_BASE + g);

    always_ff @(posedge clk) begin
      if (!rst_n) dir_q[g] <= '0;
      else if (cfg_wr && cfg_addr == DIR_ADDR) dir_q[g] <= cfg_wdata;
    end

    AST_DIR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr == DIR_ADDR) |=> dir_q[g] == $past(cfg_wdata)) else $error("dir store"); // R4

    if (g < FUNC_GROUPS) begin : g_sw
      logic [GROUP_W-1:0] func_q;
      always_ff @(posedge clk) begin
        if (!rst_n) func_q <= '0;
        else if (cfg_wr && cfg_addr == FUNC_ADDR) func_q <= cfg_wdata;
      end
      assign func_rb[g] = func_q;
      assign func_en[g] = func_q;

      AST_FUNC_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == FUNC_ADDR) |=> func_q == $past(cfg_wdata)) else $error("func store"); // R5
    end else begin : g_fixed
      assign func_rb[g] = '0;
      assign func_en[g] = '1;

      AST_FIXED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr == FUNC_ADDR) |=> cfg_rdata == '0) else $error("fixed read"); // R10
    end

    assign dir_flat[g*GROUP_W +: GROUP_W]  = dir_q[g];
    assign func_flat[g*GROUP_W +: GROUP_W] = func_en[g];
  end

  function automatic cfg_kind_e kind_of(input logic [CFG_AW-1:0] a, input int g);
    if (a == CFG_AW'(DIR_BASE + g)) return CFG_DIR;
    if (a == CFG_AW'(FUNC_BASE + g)) return CFG_FUNC;
    return CFG_NONE;
  endfunction

  always_comb begin
    rd_next = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      case (kind_of(cfg_addr, g))
        CFG_DIR:  rd_next = dir_q[g];
        CFG_FUNC: rd_next = func_rb[g];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_rdata <= '0;
    else        cfg_rdata <= cfg_rd ? rd_next : '0;
  end

  AST_CFG_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_rd) |-> cfg_rdata == '0) else $error("cfg idle"); // R10

  initial begin
    if (LINES < 1) $error("no lines");
  end
endmodule

// File: rtl/gpio_io_window.sv
module gpio_io_window
  import gpio_bank_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int GROUP_W    = 8,
  parameter int AW         = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [AW-1:0]                 io_base,
  input  logic [AW-1:0]                 io_addr,
  input  logic                          io_wr,
  input  logic                          io_rd,
  input  logic [GROUP_W-1:0]            io_wdata,
  output logic [GROUP_W-1:0]            io_rdata,
  output logic                          io_rvalid,
  input  logic [NUM_GROUPS*GROUP_W-1:0] line_oe,
  input  logic [NUM_GROUPS*GROUP_W-1:0] line_lvl,
  output logic [NUM_GROUPS*GROUP_W-1:0] drive_flat
);
  localparam int IDX_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  logic [AW:0]        offset;
  logic               hit;
  logic [IDX_W-1:0]   idx;
  logic [GROUP_W-1:0] drive_q [NUM_GROUPS];
  logic [GROUP_W-1:0] view    [NUM_GROUPS];

  // widen by one bit so an address below the base never aliases into the window
  assign offset = {1'b0, io_addr} - {1'b0, io_base};
  assign hit    = !offset[AW] && (offset[AW-1:0] < AW'(NUM_GROUPS));
  assign idx    = offset[IDX_W-1:0];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_dat
    always_ff @(posedge clk) begin
      if (!rst_n) drive_q[g] <= '0;
      else if (io_wr && hit && idx == IDX_W'(g)) drive_q[g] <= io_wdata;
    end
    assign view[g] = mix_byte(drive_q[g], line_lvl[g*GROUP_W +: GROUP_W],
                              line_oe[g*GROUP_W +: GROUP_W]);
    assign drive_flat[g*GROUP_W +: GROUP_W] = drive_q[g];

    AST_DATA_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && hit && idx == IDX_W'(g)) |=> drive_q[g] == $past(io_wdata)) else $error("data store"); // R1
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_rvalid <= 1'b0;
      io_rdata  <= '0;
    end else begin
      io_rvalid <= io_rd && hit;
      io_rdata  <= (io_rd && hit) ? view[idx] : '0;
    end
  end

  AST_RVALID_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    io_rvalid |-> $past(io_rd)) else $error("rvalid without rd"); // R2
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rvalid |-> io_rdata == '0) else $error("rdata not quiet"); // R3
  AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !hit) |=> $stable(drive_flat)) else $error("miss wrote"); // R3
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int NUM_GROUPS  = 8,
  parameter int GROUP_W     = 8,
  parameter int FUNC_GROUPS = 5,
  parameter int FUNC_BASE   = 'hC0,
  parameter int DIR_BASE    = 'hC8,
  parameter int AW          = 16,
  parameter int CFG_AW      = 8,
  localparam int LINES      = NUM_GROUPS * GROUP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     io_base,
  input  logic [AW-1:0]     io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [GROUP_W-1:0] io_wdata,
  output logic [GROUP_W-1:0] io_rdata,
  output logic              io_rvalid,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [GROUP_W-1:0] cfg_wdata,
  output logic [GROUP_W-1:0] cfg_rdata,
  input  logic [LINES-1:0]  pad_in,
  output logic [LINES-1:0]  pad_out,
  output logic [LINES-1:0]  pad_oe
);
  logic [LINES-1:0] dir_flat;
  logic [LINES-1:0] func_flat;
  logic [LINES-1:0] lvl_sync;

  gpio_cfg_bank #(
    .NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W), .FUNC_GROUPS(FUNC_GROUPS),
    .FUNC_BASE(FUNC_BASE), .DIR_BASE(DIR_BASE), .CFG_AW(CFG_AW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
    .cfg_rd(cfg_rd), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .dir_flat(dir_flat), .func_flat(func_flat)
  );

  gpio_in_sync #(.WIDTH(LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(lvl_sync)
  );

  assign pad_oe = dir_flat & func_flat;

  gpio_io_window #(
    .NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W), .AW(AW)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .io_base(io_base), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_rvalid(io_rvalid), .line_oe(pad_oe), .line_lvl(lvl_sync),
    .drive_flat(pad_out)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rst_n) |-> (pad_oe == '0 && pad_out == '0)) else $error("reset state"); // R7
  AST_OE_NEEDS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir_flat) == '0) else $error("oe without dir"); // R5
endmodule

// File: tb/sim_gpio_bank_ctrl.sv
module sim_gpio_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_base = 16'h0A00;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_rvalid;
  logic [7:0]  cfg_addr = '0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [63:0] pad_in = '0;
  logic [63:0] pad_out, pad_oe;

  int total = 0;
  int bad = 0;
  logic [63:0] exp_out = '0;
  logic [63:0] exp_oe = '0;
  logic [7:0]  rb;
  logic        rv;

  always #2.5 clk = ~clk;

  gpio_bank_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .io_base(io_base), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_rvalid(io_rvalid), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
    .cfg_rd(cfg_rd), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0; rb = io_rdata; rv = io_rvalid;
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a);
    @(negedge clk); cfg_addr = a; cfg_rd = 1'b1;
    @(negedge clk); cfg_rd = 1'b0; rb = cfg_rdata;
  endtask

  task automatic t_reset;
    chk("R7 pad_oe", pad_oe, '0);
    chk("R7 pad_out", pad_out, '0);
    cfg_read(8'hC8); chk("R7 dir reg", 64'(rb), 0);
    cfg_read(8'hC0); chk("R7 func reg", 64'(rb), 0);
    chk("R2 idle rvalid", 64'(io_rvalid), 0);
  endtask

  task automatic t_window;
    io_base = 16'h0A00;
    for (int g = 0; g < 8; g++) begin
      io_write(io_base + 16'(g), 8'(8'h11 * (g + 1)));
      exp_out[g*8 +: 8] = 8'(8'h11 * (g + 1));
    end
    @(negedge clk);
    chk("R1 R11 group bytes", pad_out, exp_out);
    io_read(16'h0A03);
    chk("R2 rvalid", 64'(rv), 1);
    chk("R8 input low", 64'(rb), 0);
    pad_in = {8{8'hA5}};
    repeat (3) @(negedge clk);
    io_read(16'h0A05);
    chk("R8 synced level", 64'(rb), 64'hA5);
  endtask

  task automatic t_boundary;
    io_write(16'h0A08, 8'hEE);
    io_write(16'h09FF, 8'hEE);
    @(negedge clk);
    chk("R3 miss writes", pad_out, exp_out);
    io_read(16'h0A08);
    chk("R3 miss rvalid", 64'(rv), 0);
    chk("R3 miss rdata", 64'(rb), 0);
    io_base = 16'hFFFC;
    io_write(16'hFFFF, 8'h3C);
    exp_out[31:24] = 8'h3C;
    io_write(16'h0000, 8'hEE);
    io_write(16'h0003, 8'hEE);
    @(negedge clk);
    chk("R3 R1 top of space no wrap", pad_out, exp_out);
    io_base = 16'h0A00;
  endtask

  task automatic t_enables;
    cfg_write(8'hCA, 8'hFF);
    @(negedge clk);
    chk("R5 dir alone", pad_oe, exp_oe);
    cfg_write(8'hC2, 8'h0F);
    exp_oe[23:16] = 8'h0F;
    @(negedge clk);
    chk("R5 both enables", pad_oe, exp_oe);
    cfg_read(8'hC2); chk("R5 func readback", 64'(rb), 64'h0F);
    cfg_read(8'hCA); chk("R4 dir readback", 64'(rb), 64'hFF);
    io_read(16'h0A02);
    chk("R9 mixed driven byte", 64'(rb), 64'hA3);
    cfg_write(8'hCE, 8'hF0);
    exp_oe[55:48] = 8'hF0;
    @(negedge clk);
    chk("R6 fixed group", pad_oe, exp_oe);
    io_read(16'h0A06);
    chk("R9 fixed group read", 64'(rb), 64'h75);
  endtask

  task automatic t_unimpl;
    cfg_write(8'hC6, 8'hFF);
    cfg_write(8'h50, 8'hFF);
    @(negedge clk);
    chk("R10 ignored writes", pad_oe, exp_oe);
    cfg_read(8'hC6); chk("R10 C6 reads zero", 64'(rb), 0);
    cfg_read(8'hC5); chk("R10 C5 reads zero", 64'(rb), 0);
    cfg_read(8'h50); chk("R10 unmapped zero", 64'(rb), 0);
    cfg_read(8'hCE); chk("R4 dir g6 kept", 64'(rb), 64'hF0);
  endtask

  task automatic t_single_line;
    cfg_write(8'hC4, 8'h20);
    cfg_write(8'hCC, 8'h20);
    exp_oe[39:32] = 8'h20;
    @(negedge clk);
    chk("R11 line37 oe", pad_oe, exp_oe);
    io_read(16'h0A04);
    chk("R11 R9 rmw read", 64'(rb), 64'h85);
    io_write(16'h0A04, rb | 8'h20);
    exp_out[39:32] = 8'hA5;
    @(negedge clk);
    chk("R11 line37 driven high", 64'(pad_out[37]), 1);
    chk("R1 rmw byte", pad_out, exp_out);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window();
    t_boundary();
    t_enables();
    t_unimpl();
    t_single_line();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule